// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from a parameterised number of sources (64 by default) and hands the CPU one request at a time. Each source has a pending flag, an enable bit, a 5-bit priority (a 3-bit major level above a 2-bit sub level) and a vector offset. Each cycle the controller picks the best pending, enabled source. One cycle later it raises `irq_o`, shows the source number and drives that source's vector offset.

A per-source parameter marks each source as level (persistent) or edge (non-persistent). A level source keeps its flag set for as long as its request line is high, and software cannot clear the flag until the line drops. An edge source latches a rising edge. The lowest-numbered sources take their request from dedicated external pins instead of the source bus, and each of these pins has its own programmable edge polarity.

Software sets up the block through a word-addressed register port. The flag, enable, priority and control words each have three addresses: one replaces the whole word, one clears the bits written as 1, and one sets the bits written as 1.

Top module: `virq_ctrl`

## Requirements
- R1: After reset `irq_o` is 0, `irq_id_o` and `irq_vec_o` are 0, and every control, flag, enable, priority and status word reads 0.
- R2: For the control, flag, enable and priority words, a write to the word address replaces the word, a write to address+0x4 clears the bits written as 1, and a write to address+0x8 sets the bits written as 1. Reads at any of the three addresses return the word.
- R3: The flag and enable bits of source n sit at bit n%32 of word n/32. Flag words start at 0x040 and enable words start at 0x0C0, with a stride of 0x10 between words.
- R4: The priority of source n sits in bits (n%4)*8+4 down to (n%4)*8 of the priority word at 0x140+0x10*(n/4). Bits 4:2 of the field are the major level and bits 1:0 are the sub level. The upper three bits of each byte lane read 0.
- R5: The vector offset of source n is the low 16 bits of the word at 0x540+4*n. The word is written only by replacement, and `irq_vec_o` carries the selected source's offset.
- R6: An edge source sets its flag on a 0-to-1 change of its request. The flag stays set after the request drops, until software clears it.
- R7: A level source's flag is set in every cycle in which its request is high. A clear write has no effect while the request is high. The flag stays set after the request drops, until software clears it.
- R8: Sources 0 to N_EXT-1 take their request from `ext_i` and ignore `src_i`. Control bit k selects rising-edge detection on `ext_i[k]` when 1 and falling-edge detection when 0. The control word has N_EXT bits.
- R9: Among the sources whose flag and enable are both 1, the controller selects the highest 5-bit priority value, which orders by major level first and sub level second. Ties go to the lowest source number. A source with major level 0 is never selected.
- R10: `irq_o`, `irq_id_o` and `irq_vec_o` follow the selection with one cycle of latency. When no source is selected, `irq_o` is 0. The status word at 0x020 reads `{irq_o, 23'b0, irq_id_o}`.
- R11: If a hardware set and a software clear reach the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 12 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from `bus_addr_i` |
| src_i | input | N_SRC | Source request lines |
| ext_i | input | N_EXT | External interrupt pins for sources 0..N_EXT-1 |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_id_o | output | 8 | Number of the selected source |
| irq_vec_o | output | VEC_W | Vector offset of the selected source |

## Verification
A flag can receive a hardware set and a software clear-alias write in the same cycle. Two cases provoke this. In the first, the bench raises an edge source's request and writes its clear alias at the same clock edge; the flag must read back set afterwards. In the second, the bench holds a level source high while it writes that source's clear alias; the flag, and the interrupt it drives, must both survive. The bench also stacks several pending sources at once to check the order of selection: major level first, then sub level, then lowest number.

// File: rtl/virq_pkg.sv
`timescale 1ns/1ps
package virq_pkg;
  localparam int unsigned PRIO_W    = 5;
  localparam int unsigned CTRL_BASE = 32'h000;
  localparam int unsigned STAT_BASE = 32'h020;
  localparam int unsigned FLAG_BASE = 32'h040;
  localparam int unsigned EN_BASE   = 32'h0C0;
  localparam int unsigned PRIO_BASE = 32'h140;
  localparam int unsigned VEC_BASE  = 32'h540;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_CLR   = 2'd1,
    OP_SET   = 2'd2,
    OP_NONE  = 2'd3
  } wr_op_e;

  function automatic logic [31:0] apply_op(logic [31:0] cur, logic [31:0] wd, wr_op_e op);
    unique case (op)
      OP_WRITE: return wd;
      OP_CLR:   return cur & ~wd;
      OP_SET:   return cur | wd;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/virq_sense.sv
`timescale 1ns/1ps
module virq_sense #(
  parameter int unsigned N_SRC = 64,
  parameter int unsigned N_EXT = 4,
  parameter logic [N_SRC-1:0] LEVEL_MASK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_EXT-1:0] ext_i,
  input  logic [N_EXT-1:0] pol_i,
  output logic [N_SRC-1:0] hit_o,
  output logic [N_SRC-1:0] hold_o
);
  // external sources take no request from src_i
  logic unused_src;
  assign unused_src = ^src_i[N_EXT-1:0];

  for (genvar n = 0; n < N_SRC; n++) begin : g_src
    if (n < N_EXT) begin : g_ext
      logic pin_q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pin_q <= 1'b0;
        else         pin_q <= ext_i[n];
      assign hit_o[n]  = (ext_i[n] != pin_q) && (ext_i[n] == pol_i[n]);
      assign hold_o[n] = 1'b0;
    end else if (LEVEL_MASK[n]) begin : g_lvl
      assign hit_o[n]  = 1'b0;
      assign hold_o[n] = src_i[n];
    end else begin : g_edge
      logic req_q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) req_q <= 1'b0;
        else         req_q <= src_i[n];
      assign hit_o[n]  = src_i[n] & ~req_q;
      assign hold_o[n] = 1'b0;
    end
  end
endmodule

// File: rtl/virq_arbiter.sv
`timescale 1ns/1ps
module virq_arbiter import virq_pkg::*; #(
  parameter int unsigned N_SRC = 64,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]             cand_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                         win_v_o,
  output logic [IDX_W-1:0]             win_idx_o
);
  logic [PRIO_W-1:0] best_p;

  // descending scan with >= lets the lowest index win a tie
  always_comb begin
    win_v_o   = 1'b0;
    win_idx_o = '0;
    best_p    = '0;
    for (int n = N_SRC - 1; n >= 0; n--) begin
      if (cand_i[n] && (prio_i[n][PRIO_W-1:2] != '0) && (!win_v_o || prio_i[n] >= best_p)) begin
        win_v_o   = 1'b1;
        win_idx_o = IDX_W'(n);
        best_p    = prio_i[n];
      end
    end
  end
endmodule

// File: rtl/virq_ctrl.sv
`timescale 1ns/1ps
module virq_ctrl import virq_pkg::*; #(
  parameter int unsigned N_SRC = 64,
  parameter int unsigned N_EXT = 4,
  parameter int unsigned VEC_W = 16,
  parameter logic [N_SRC-1:0] LEVEL_MASK = {{(N_SRC/2){1'b1}}, {(N_SRC/2){1'b0}}}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic [11:0]      bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_EXT-1:0] ext_i,
  output logic             irq_o,
  output logic [7:0]       irq_id_o,
  output logic [VEC_W-1:0] irq_vec_o
);
  localparam int unsigned IDX_W = $clog2(N_SRC);
  localparam int unsigned N_FW  = N_SRC / 32;
  localparam int unsigned N_PW  = N_SRC / 4;
  localparam int unsigned FW_W  = (N_FW > 1) ? $clog2(N_FW) : 1;
  localparam int unsigned PW_W  = (N_PW > 1) ? $clog2(N_PW) : 1;
  localparam int unsigned FLAG_END = FLAG_BASE + 16 * N_FW;
  localparam int unsigned EN_END   = EN_BASE + 16 * N_FW;
  localparam int unsigned PRIO_END = PRIO_BASE + 16 * N_PW;
  localparam int unsigned VEC_END  = VEC_BASE + 4 * N_SRC;
  localparam logic [N_SRC-1:0] LVL_EFF = LEVEL_MASK & ~N_SRC'((64'd1 << N_EXT) - 64'd1);

  logic [N_EXT-1:0]                 ctrl_q, ctrl_d;
  logic [N_FW-1:0][31:0]            flag_q, flag_sw, flag_d, en_q, en_d;
  logic [N_PW-1:0][3:0][PRIO_W-1:0] prio_q, prio_d;
  logic [VEC_W-1:0]                 vec_q [N_SRC];
  logic [N_SRC-1:0][PRIO_W-1:0]     prio_flat;
  logic [N_SRC-1:0]                 hit_w, hold_w, cand;

  logic                 irq_q;
  logic [IDX_W-1:0]     id_q;
  logic [VEC_W-1:0]     vout_q;
  logic                 win_v;
  logic [IDX_W-1:0]     win_idx;

  // address decode
  int unsigned     a_int;
  logic            hit_ctrl, hit_stat, hit_flag, hit_en, hit_prio, hit_vec;
  logic [FW_W-1:0] fw, ew;
  logic [PW_W-1:0] pw;
  logic [IDX_W-1:0] vw;
  wr_op_e          op;

  always_comb begin
    a_int    = 32'(bus_addr_i);
    op       = wr_op_e'(bus_addr_i[3:2]);
    hit_ctrl = a_int < STAT_BASE;
    hit_stat = (a_int >= STAT_BASE) && (a_int < STAT_BASE + 16);
    hit_flag = (a_int >= FLAG_BASE) && (a_int < FLAG_END);
    hit_en   = (a_int >= EN_BASE)   && (a_int < EN_END);
    hit_prio = (a_int >= PRIO_BASE) && (a_int < PRIO_END);
    hit_vec  = (a_int >= VEC_BASE)  && (a_int < VEC_END);
    fw = hit_flag ? FW_W'((a_int - FLAG_BASE) >> 4) : '0;
    ew = hit_en   ? FW_W'((a_int - EN_BASE) >> 4)   : '0;
    pw = hit_prio ? PW_W'((a_int - PRIO_BASE) >> 4) : '0;
    vw = hit_vec  ? IDX_W'((a_int - VEC_BASE) >> 2) : '0;
  end

  // software side of the register update
  always_comb begin
    ctrl_d  = ctrl_q;
    flag_sw = flag_q;
    en_d    = en_q;
    prio_d  = prio_q;
    if (bus_we_i) begin
      if (hit_ctrl) ctrl_d = N_EXT'(apply_op(32'(ctrl_q), bus_wdata_i, op));
      if (hit_flag) flag_sw[fw] = apply_op(flag_q[fw], bus_wdata_i, op);
      if (hit_en)   en_d[ew]    = apply_op(en_q[ew], bus_wdata_i, op);
      if (hit_prio) begin
        for (int l = 0; l < 4; l++)
          prio_d[pw][l] = PRIO_W'(apply_op(32'(prio_q[pw][l]), 32'(bus_wdata_i[8*l +: 8]), op));
      end
    end
  end

  // hardware set and level hold override a clear in the same cycle
  assign flag_d = flag_sw | hit_w | hold_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      flag_q <= '0;
      en_q   <= '0;
      prio_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
      en_q   <= en_d;
      prio_q <= prio_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < N_SRC; n++) vec_q[n] <= '0;
    end else if (bus_we_i && hit_vec) begin
      vec_q[vw] <= bus_wdata_i[VEC_W-1:0];
    end
  end

  virq_sense #(
    .N_SRC(N_SRC), .N_EXT(N_EXT), .LEVEL_MASK(LEVEL_MASK)
  ) u_sense (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (src_i),
    .ext_i (ext_i),
    .pol_i (ctrl_q),
    .hit_o (hit_w),
    .hold_o(hold_w)
  );

  assign prio_flat = prio_q;
  assign cand      = flag_q & en_q;

  virq_arbiter #(.N_SRC(N_SRC)) u_arb (
    .cand_i   (cand),
    .prio_i   (prio_flat),
    .win_v_o  (win_v),
    .win_idx_o(win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      id_q   <= '0;
      vout_q <= '0;
    end else begin
      irq_q  <= win_v;
      id_q   <= win_v ? win_idx : '0;
      vout_q <= win_v ? vec_q[win_idx] : '0;
    end
  end

  assign irq_o     = irq_q;
  assign irq_id_o  = 8'(id_q);
  assign irq_vec_o = vout_q;

  always_comb begin
    bus_rdata_o = '0;
    if (hit_ctrl)      bus_rdata_o = 32'(ctrl_q);
    else if (hit_stat) bus_rdata_o = {irq_q, 23'b0, 8'(id_q)};
    else if (hit_flag) bus_rdata_o = flag_q[fw];
    else if (hit_en)   bus_rdata_o = en_q[ew];
    else if (hit_prio) begin
      for (int l = 0; l < 4; l++) bus_rdata_o[8*l +: 8] = 8'(prio_q[pw][l]);
    end
    else if (hit_vec)  bus_rdata_o = 32'(vec_q[vw]);
  end

  // R7: a level request seen at an edge leaves its flag set
  p_level_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(src_i) & LVL_EFF) & ~flag_d) == '0 || ((($past(src_i) & LVL_EFF) & ~flag_q) == '0)));

  // R11: an edge hit is never lost to a concurrent clear
  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(hit_w) & ~flag_q) == '0));

  // R10: a raised request points at a source that was pending and enabled
  p_irq_source_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(($past(cand) >> id_q) & N_SRC'(1)));

  // R10: nothing pending means no request next cycle
  p_idle_no_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand == '0) |=> !irq_o);

  // R9: the chosen source is a candidate with nonzero major level
  p_major_nz_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_v |-> (cand[win_idx] && (prio_flat[win_idx][PRIO_W-1:2] != '0)));
endmodule

// File: tb/virq_ctrl_tb.sv
`timescale 1ns/1ps
module virq_ctrl_tb;
  logic        clk;
  logic        rst_n;
  logic        we;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [63:0] src;
  logic [3:0]  ext;
  logic        irq;
  logic [7:0]  irq_id;
  logic [15:0] irq_vec;

  virq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .src_i(src), .ext_i(ext),
    .irq_o(irq), .irq_id_o(irq_id), .irq_vec_o(irq_vec)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    string       tag;
    bit          is_rd;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic [7:0]  exp_id;
    logic [15:0] exp_vec;
  } item_t;

  item_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;

  // monitor: pop one expected item per falling edge
  always @(negedge clk) begin
    item_t it;
    if (sb_q.size() != 0) begin
      it = sb_q.pop_front();
      n_cmp++;
      if (it.is_rd) begin
        if (rdata !== it.exp_rd) begin
          n_bad++;
          $display("FAIL %s: rdata actual=%h expected=%h", it.tag, rdata, it.exp_rd);
        end
      end else if ({irq, irq_id, irq_vec} !== {it.exp_irq, it.exp_id, it.exp_vec}) begin
        n_bad++;
        $display("FAIL %s: irq/id/vec actual=%0b/%0d/%h expected=%0b/%0d/%h",
                 it.tag, irq, irq_id, irq_vec, it.exp_irq, it.exp_id, it.exp_vec);
      end
    end
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic exp_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    addr = a;
    it.tag = tag; it.is_rd = 1'b1; it.exp_rd = e;
    it.exp_irq = 1'b0; it.exp_id = '0; it.exp_vec = '0;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
    step();
  endtask

  task automatic exp_irq(input logic v, input logic [7:0] id, input logic [15:0] vec, input string tag);
    item_t it;
    it.tag = tag; it.is_rd = 1'b0; it.exp_rd = '0;
    it.exp_irq = v; it.exp_id = id; it.exp_vec = vec;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (R1..): actual=running expected=done");
    report();
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; src = '0; ext = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    exp_irq(1'b0, 8'd0, 16'h0, "R1 irq");
    exp_rd(12'h000, 32'h0, "R1 ctrl");
    exp_rd(12'h040, 32'h0, "R1 flag");
    exp_rd(12'h0D0, 32'h0, "R1 enable");
    exp_rd(12'h140, 32'h0, "R1 prio");
    exp_rd(12'h020, 32'h0, "R1 status");

    // R2 R3 enable word aliases
    wr(12'h0C0, 32'hA5A5_0000);
    exp_rd(12'h0C0, 32'hA5A5_0000, "R2 replace");
    wr(12'h0C8, 32'h0000_000F);
    exp_rd(12'h0C4, 32'hA5A5_000F, "R2 set alias");
    wr(12'h0C4, 32'hA000_0001);
    exp_rd(12'h0C0, 32'h05A5_000E, "R2 clear alias");
    wr(12'h0D0, 32'h0000_0001);
    exp_rd(12'h0D0, 32'h0000_0001, "R3 enable word1");
    wr(12'h0C0, 32'h0);
    wr(12'h0D0, 32'h0);

    // R8 R2 control width and aliases
    wr(12'h000, 32'hFFFF_FFFF);
    exp_rd(12'h000, 32'h0000_000F, "R8 ctrl width");
    wr(12'h004, 32'h5);
    exp_rd(12'h000, 32'h0000_000A, "R2 ctrl clear");
    wr(12'h008, 32'h1);
    exp_rd(12'h000, 32'h0000_000B, "R2 ctrl set");
    wr(12'h000, 32'h0);

    // R4 priority lanes
    wr(12'h150, 32'hFFFF_FFFF);
    exp_rd(12'h150, 32'h1F1F_1F1F, "R4 lane mask");
    wr(12'h154, 32'h0000_0300);
    exp_rd(12'h150, 32'h1F1F_1C1F, "R4 lane clear");
    wr(12'h150, 32'h0);

    // R5 vector entry
    wr(12'h5D4, 32'hABCD_1234);
    exp_rd(12'h5D4, 32'h0000_1234, "R5 vector width");

    // R6 R10 edge source 10, priority 0x08
    wr(12'h160, 32'h0008_0000);
    wr(12'h568, 32'h0000_0100);
    wr(12'h0C0, 32'h0000_0400);
    src[10] = 1'b1;
    step();
    exp_irq(1'b0, 8'd0, 16'h0, "R10 latency first cycle");
    exp_irq(1'b1, 8'd10, 16'h0100, "R10 irq source 10");
    src[10] = 1'b0;
    step(); step();
    exp_irq(1'b1, 8'd10, 16'h0100, "R6 flag latched");
    exp_rd(12'h040, 32'h0000_0400, "R6 flag bit 10");
    exp_rd(12'h020, 32'h8000_000A, "R10 status");
    wr(12'h044, 32'h0000_0400);
    exp_rd(12'h040, 32'h0, "R6 software clear");
    exp_irq(1'b0, 8'd0, 16'h0, "R10 idle");

    // R7 level source 40, priority 0x0C
    wr(12'h1E0, 32'h0000_000C);
    wr(12'h5E0, 32'h0000_0200);
    wr(12'h0D0, 32'h0000_0100);
    src[40] = 1'b1;
    step(); step();
    exp_irq(1'b1, 8'd40, 16'h0200, "R7 level irq");
    wr(12'h054, 32'h0000_0100);
    exp_rd(12'h050, 32'h0000_0100, "R7 clear ignored while high");
    exp_irq(1'b1, 8'd40, 16'h0200, "R7 irq kept");
    src[40] = 1'b0;
    step();
    exp_rd(12'h050, 32'h0000_0100, "R7 flag kept after drop");
    wr(12'h054, 32'h0000_0100);
    exp_rd(12'h050, 32'h0, "R7 clear after drop");
    exp_irq(1'b0, 8'd0, 16'h0, "R7 idle");

    // R9 arbitration
    src[40] = 1'b1;
    step(); step();
    wr(12'h048, 32'h0000_0400);
    step();
    exp_irq(1'b1, 8'd40, 16'h0200, "R9 major wins");
    wr(12'h160, 32'h000D_0000);
    step();
    exp_irq(1'b1, 8'd10, 16'h0100, "R9 sub level");
    wr(12'h160, 32'h0D0D_0000);
    wr(12'h56C, 32'h0000_0110);
    wr(12'h0C8, 32'h0000_0800);
    wr(12'h048, 32'h0000_0800);
    step();
    exp_irq(1'b1, 8'd10, 16'h0100, "R9 tie lowest number");
    wr(12'h044, 32'h0000_0400);
    step();
    exp_irq(1'b1, 8'd11, 16'h0110, "R9 tie next");
    src[40] = 1'b0;
    wr(12'h054, 32'h0000_0100);
    wr(12'h044, 32'h0000_0800);
    wr(12'h170, 32'h0000_0003);
    wr(12'h0C8, 32'h0000_1000);
    wr(12'h048, 32'h0000_1000);
    step(); step();
    exp_irq(1'b0, 8'd0, 16'h0, "R9 major zero skipped");
    exp_rd(12'h040, 32'h0000_1000, "R9 major zero flag pending");
    wr(12'h044, 32'h0000_1000);

    // R8 external pin 2, priority 0x1C
    wr(12'h140, 32'h001C_0000);
    wr(12'h548, 32'h0000_0300);
    wr(12'h0C8, 32'h0000_0004);
    ext[2] = 1'b1;
    step(); step();
    exp_rd(12'h040, 32'h0, "R8 rise ignored in falling mode");
    ext[2] = 1'b0;
    step();
    exp_rd(12'h040, 32'h0000_0004, "R8 falling edge");
    exp_irq(1'b1, 8'd2, 16'h0300, "R8 ext irq");
    wr(12'h044, 32'h0000_0004);
    wr(12'h008, 32'h0000_0004);
    src[2] = 1'b1;
    step(); step();
    exp_rd(12'h040, 32'h0, "R8 src_i ignored");
    src[2] = 1'b0;
    ext[2] = 1'b1;
    step();
    exp_rd(12'h040, 32'h0000_0004, "R8 rising edge");
    ext[2] = 1'b0;
    wr(12'h044, 32'h0000_0004);
    exp_rd(12'h040, 32'h0, "R8 cleared");

    // R11 edge and clear in the same cycle
    src[10] = 1'b1;
    wr(12'h044, 32'h0000_0400);
    exp_rd(12'h040, 32'h0000_0400, "R11 set wins");
    exp_rd(12'h020, 32'h8000_000A, "R11 status");
    src[10] = 1'b0;
    wr(12'h044, 32'h0000_0400);
    exp_rd(12'h040, 32'h0, "R11 later clear");

    report();
  end
endmodule